// File: doc/BRIEF.md
# Event-Triggered Single-Transfer DMA Controller

This block copies one data item from a source address to a destination address each time a peripheral raises its request, for example when a serial receiver has a byte ready. It holds one channel descriptor: a source address, a destination address, a transfer count, and mode fields. The mode fields choose how each address steps, the transfer unit size, and when the CPU is interrupted. Each transfer is one read cycle followed by one write cycle on a simple single-cycle memory bus.

After a transfer that is not the last one, the controller pulses an acknowledge so that the peripheral clears its ready flag. The CPU sees nothing in that case. When the count runs out, the controller sends no acknowledge, so the ready flag stays set. It also clears its own channel enable, and from then on the still-pending request appears on the CPU interrupt output. A second option forwards the interrupt after every transfer. While the channel is disabled, requests pass straight through to the CPU.

Top module: `ev_xfer_dma`

## Requirements
- R1: After reset the channel is disabled and no read, write or acknowledge is driven.
- R2: When the channel is enabled, idle and not waiting on a forwarded request, a request seen at a clock edge starts a read cycle in the next cycle. The read uses the source address, and `mem_size` shows the unit code.
- R3: Every read cycle is followed at once by exactly one write cycle. The write goes to the destination address and carries the data returned in the read cycle.
- R4: After each transfer the source address is updated by the source step code: 00 or 01 holds it, 10 adds the unit size, 11 subtracts it.
- R5: The destination address is updated by its own step code, with the same encoding as R4.
- R6: Unit code 00 is one byte (step 1), 01 is two bytes (step 2), and 10 and 11 are four bytes (step 4).
- R7: Each transfer decrements the count. When a transfer does not end the count and the interrupt-each bit is 0, `evt_ack` is high during its write cycle and `cpu_irq` stays low.
- R8: When a transfer brings the count to zero, there is no acknowledge and the enable is cleared. From the next cycle on, `cpu_irq` follows `evt_req`.
- R9: With the interrupt-each bit at 1, a transfer that does not end the count gives no acknowledge. From the next cycle `cpu_irq` follows `evt_req`, and no new transfer starts until `evt_req` has been low at a clock edge.
- R10: While the channel is disabled, `cpu_irq` equals `evt_req` and no memory cycle is started.
- R11: A loaded count of zero means 65536 transfers, so the first transfer after loading zero is not the last one.
- R12: Address steps wrap modulo 2^32.
- R13: Requests arriving during a transfer, and descriptor loads presented during a transfer, have no effect. A load is taken only in an idle cycle, and a load takes precedence over a request in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the descriptor fields and the enable in an idle cycle |
| cfg_enable | input | 1 | Channel enable value to load |
| cfg_src_addr | input | 32 | Source address to load |
| cfg_dst_addr | input | 32 | Destination address to load |
| cfg_count | input | 16 | Transfer count to load (0 means 65536) |
| cfg_src_step | input | 2 | Source step code (R4) |
| cfg_dst_step | input | 2 | Destination step code (R5) |
| cfg_size | input | 2 | Unit size code (R6) |
| cfg_irq_each | input | 1 | 1: forward the interrupt after every transfer |
| evt_req | input | 1 | Peripheral ready flag / request |
| evt_ack | output | 1 | Clears the peripheral ready flag at the end of the cycle |
| cpu_irq | output | 1 | Request forwarded to the CPU |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_addr | output | 32 | Bus address |
| mem_size | output | 2 | Unit size code of the current cycle |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read cycle itself |

## Verification
The assertions rely on the bus returning read data in the same cycle as `mem_rd`, because the data check compares the write data with the value present on `mem_rdata` one cycle earlier. The assertions also assume that the peripheral treats `evt_ack` as a clear of its flag at that clock edge. The bench follows both rules: its memory model is purely combinational, and its peripheral model lowers the flag only on an acknowledge, except in one deliberate case where the flag is dropped in the middle of a transfer to show that the transfer still completes. Descriptor loads are normally issued in idle cycles, and one test deliberately presents a load while the channel is busy.

// File: rtl/evdma_pkg.sv
package evdma_pkg;

    typedef enum logic [1:0] {
        STEP_KEEP     = 2'b00,
        STEP_KEEP_ALT = 2'b01,
        STEP_UP       = 2'b10,
        STEP_DOWN     = 2'b11
    } step_mode_e;

    typedef enum logic [1:0] {
        UNIT_8   = 2'b00,
        UNIT_16  = 2'b01,
        UNIT_32  = 2'b10,
        UNIT_RSV = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_READ  = 2'b01,
        PH_WRITE = 2'b10
    } phase_e;

    typedef struct packed {
        step_mode_e src_step;
        step_mode_e dst_step;
        unit_e      unit;
        logic       irq_each;
    } xfer_mode_t;

    function automatic logic [2:0] unit_bytes(unit_e u);
        case (u)
            UNIT_8:  return 3'd1;
            UNIT_16: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/evdma_addr_reg.sv
module evdma_addr_reg
    import evdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  step_mode_e        mode,
    input  unit_e             unit,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned PAD_W = ADDR_W - 3;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] delta;

    always_comb delta = {{PAD_W{1'b0}}, unit_bytes(unit)};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            case (mode)
                STEP_UP:   addr_q <= addr_q + delta;
                STEP_DOWN: addr_q <= addr_q - delta;
                default:   addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

    // R4
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (mode == STEP_KEEP || mode == STEP_KEEP_ALT)) |=> $stable(addr_q));

endmodule

// File: rtl/evdma_counter.sv
module evdma_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

    // R11
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && cnt_q == '0) |=> !last);

endmodule

// File: rtl/evdma_seq.sv
module evdma_seq
    import evdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_req,
    input  logic load_en,
    input  logic req,
    input  logic last,
    input  logic irq_each,
    output logic take_load,
    output logic rd_o,
    output logic wr_o,
    output logic ack_o,
    output logic irq_o
);
    phase_e phase_q;
    logic   en_q;
    logic   fwd_q;
    logic   idle;
    logic   start;

    assign idle      = (phase_q == PH_IDLE);
    assign take_load = idle && load_req;
    assign start     = idle && !load_req && en_q && req && !fwd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:  phase_q <= start ? PH_READ : PH_IDLE;
                PH_READ:  phase_q <= PH_WRITE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            fwd_q <= 1'b0;
        end else begin
            if (take_load)
                en_q <= load_en;
            else if (wr_o && last)
                en_q <= 1'b0;

            if (take_load)
                fwd_q <= 1'b0;
            else if (wr_o && !last && irq_each)
                fwd_q <= 1'b1;
            else if (!req)
                fwd_q <= 1'b0;
        end
    end

    assign rd_o  = (phase_q == PH_READ);
    assign wr_o  = (phase_q == PH_WRITE);
    assign ack_o = wr_o && !last && !irq_each;
    assign irq_o = req && (!en_q || fwd_q);

    // R3
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> wr_o);

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_o && wr_o));

    // R7
    ack_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> wr_o);

    // R8
    tc_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_o && last) |=> (!en_q && !rd_o));

    // R9
    fwd_each_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_o && !last && irq_each) |=> (!req || irq_o));

    // R10
    no_access_off_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !en_q) |=> !rd_o);

endmodule

// File: rtl/ev_xfer_dma.sv
module ev_xfer_dma
    import evdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_src_step,
    input  logic [1:0]        cfg_dst_step,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_irq_each,
    input  logic              evt_req,
    output logic              evt_ack,
    output logic              cpu_irq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    xfer_mode_t        mode_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic              take_load;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (take_load) begin
            mode_q.src_step <= step_mode_e'(cfg_src_step);
            mode_q.dst_step <= step_mode_e'(cfg_dst_step);
            mode_q.unit     <= unit_e'(cfg_size);
            mode_q.irq_each <= cfg_irq_each;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (mem_rd)
            data_q <= mem_rdata;
    end

    evdma_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_req  (cfg_load),
        .load_en   (cfg_enable),
        .req       (evt_req),
        .last      (last),
        .irq_each  (mode_q.irq_each),
        .take_load (take_load),
        .rd_o      (mem_rd),
        .wr_o      (mem_wr),
        .ack_o     (evt_ack),
        .irq_o     (cpu_irq)
    );

    evdma_addr_reg #(.ADDR_W(ADDR_W)) u_src (
        .clk      (clk),
        .rst      (rst),
        .load     (take_load),
        .load_val (cfg_src_addr),
        .step     (mem_wr),
        .mode     (mode_q.src_step),
        .unit     (mode_q.unit),
        .addr     (src_addr)
    );

    evdma_addr_reg #(.ADDR_W(ADDR_W)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .load     (take_load),
        .load_val (cfg_dst_addr),
        .step     (mem_wr),
        .mode     (mode_q.dst_step),
        .unit     (mode_q.unit),
        .addr     (dst_addr)
    );

    evdma_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (take_load),
        .load_val (cfg_count),
        .dec      (mem_wr),
        .last     (last)
    );

    assign mem_addr  = mem_wr ? dst_addr : src_addr;
    assign mem_size  = mode_q.unit;
    assign mem_wdata = data_q;

    // R3
    wdata_match_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == $past(mem_rdata)));

    // R13
    load_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && cfg_load) |=> $stable(mode_q));

endmodule

// File: tb/test_ev_xfer_dma.sv
module test_ev_xfer_dma;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load, cfg_enable, cfg_irq_each;
    logic [31:0] cfg_src_addr, cfg_dst_addr;
    logic [15:0] cfg_count;
    logic [1:0]  cfg_src_step, cfg_dst_step, cfg_size;
    logic        flag;
    logic        evt_ack, cpu_irq, mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    int    checks = 0;
    int    errors = 0;
    bit    run = 1'b0;
    string tag = "R1";

    // reference model state
    int          m_ph;
    bit          m_en, m_fwd, m_each, m_last;
    int          m_cnt;
    logic [31:0] m_src, m_dst, m_data;
    logic [1:0]  m_ss, m_ds, m_sz;

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr ^ 32'h5A5A_1234;

    ev_xfer_dma i_ev_xfer_dma (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_enable   (cfg_enable),
        .cfg_src_addr (cfg_src_addr),
        .cfg_dst_addr (cfg_dst_addr),
        .cfg_count    (cfg_count),
        .cfg_src_step (cfg_src_step),
        .cfg_dst_step (cfg_dst_step),
        .cfg_size     (cfg_size),
        .cfg_irq_each (cfg_irq_each),
        .evt_req      (flag),
        .evt_ack      (evt_ack),
        .cpu_irq      (cpu_irq),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_size     (mem_size),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    function automatic logic [31:0] stepped(logic [31:0] a, logic [1:0] md, logic [1:0] sz);
        logic [31:0] d;
        d = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
        if (md == 2'b10) return a + d;
        if (md == 2'b11) return a - d;
        return a;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // reference model: advances on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_en = 0; m_fwd = 0; m_cnt = 0;
            m_src = 0; m_dst = 0; m_data = 0;
            m_ss = 0; m_ds = 0; m_sz = 0; m_each = 0;
        end else begin
            bit nen, nfwd, lst;
            lst  = (m_cnt == 1);
            nen  = m_en;
            nfwd = m_fwd;
            if (m_ph == 0 && cfg_load) begin
                nfwd = 0;
                nen  = cfg_enable;
            end else if (m_ph == 2 && !lst && m_each) begin
                nfwd = 1;
            end else if (!flag) begin
                nfwd = 0;
            end
            if (m_ph == 0) begin
                if (cfg_load) begin
                    m_src = cfg_src_addr; m_dst = cfg_dst_addr;
                    m_cnt = (cfg_count == 0) ? 65536 : int'(cfg_count);
                    m_ss = cfg_src_step; m_ds = cfg_dst_step;
                    m_sz = cfg_size; m_each = cfg_irq_each;
                end else if (m_en && flag && !m_fwd) begin
                    m_ph = 1;
                end
            end else if (m_ph == 1) begin
                m_data = m_src ^ 32'h5A5A_1234;
                m_ph = 2;
            end else begin
                if (!lst && !m_each) flag <= 1'b0;
                if (lst) nen = 0;
                m_src = stepped(m_src, m_ss, m_sz);
                m_dst = stepped(m_dst, m_ds, m_sz);
                m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
                m_ph = 0;
            end
            m_en  = nen;
            m_fwd = nfwd;
        end
    end

    // compare against the model in the middle of every cycle
    always @(negedge clk) begin
        if (run && !rst) begin
            m_last = (m_cnt == 1);
            chk(32'(mem_rd), 32'(m_ph == 1), "mem_rd");
            chk(32'(mem_wr), 32'(m_ph == 2), "mem_wr");
            chk(32'(evt_ack), 32'(m_ph == 2 && !m_last && !m_each), "evt_ack");
            chk(32'(cpu_irq), 32'(flag && (!m_en || m_fwd)), "cpu_irq");
            if (m_ph == 1) begin
                chk(mem_addr, m_src, "read addr");
                chk(32'(mem_size), 32'(m_sz), "mem_size");
            end
            if (m_ph == 2) begin
                chk(mem_addr, m_dst, "write addr");
                chk(mem_wdata, m_data, "write data");
            end
        end
    end

    task automatic load_desc(input logic en, input logic [31:0] s, input logic [31:0] d,
                             input logic [15:0] c, input logic [1:0] ss, input logic [1:0] ds,
                             input logic [1:0] sz, input logic each);
        @(negedge clk); #1;
        cfg_enable = en; cfg_src_addr = s; cfg_dst_addr = d; cfg_count = c;
        cfg_src_step = ss; cfg_dst_step = ds; cfg_size = sz; cfg_irq_each = each;
        cfg_load = 1'b1;
        @(negedge clk); #1;
        cfg_load = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk); #1;
        flag = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!flag || (m_ph == 0 && (!m_en || m_fwd))) break;
        end
        if (flag) begin
            repeat (2) @(negedge clk);
            #1 flag = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tag = "watchdog";
        checks++;
        errors++;
        $display("FAIL watchdog: act=%h exp=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_load = 1'b0; cfg_enable = 1'b0; cfg_irq_each = 1'b0;
        cfg_src_addr = '0; cfg_dst_addr = '0; cfg_count = '0;
        cfg_src_step = '0; cfg_dst_step = '0; cfg_size = '0; flag = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        run = 1'b1;

        tag = "R1";
        repeat (3) @(negedge clk);

        tag = "R10";
        fire();
        fire();

        // byte stream: fixed source, incrementing destination, count 4
        tag = "R2";
        load_desc(1'b1, 32'h0000_1000, 32'h0000_2000, 16'd4, 2'b00, 2'b10, 2'b00, 1'b0);
        fire();
        tag = "R3";
        fire();
        tag = "R7";
        fire();
        tag = "R8";
        fire();
        fire();

        tag = "R5";
        load_desc(1'b1, 32'h0000_0500, 32'h0000_3000, 16'd3, 2'b01, 2'b11, 2'b01, 1'b0);
        fire();
        fire();

        tag = "R4";
        load_desc(1'b1, 32'h0000_0100, 32'h0000_0800, 16'd3, 2'b10, 2'b00, 2'b10, 1'b0);
        fire();
        fire();
        load_desc(1'b1, 32'h0000_0900, 32'h0000_0A00, 16'd3, 2'b11, 2'b10, 2'b11, 1'b0);
        fire();
        fire();

        tag = "R6";
        load_desc(1'b1, 32'h0000_0C00, 32'h0000_0D00, 16'd3, 2'b10, 2'b10, 2'b01, 1'b0);
        fire();
        fire();

        tag = "R9";
        load_desc(1'b1, 32'h0000_4000, 32'h0000_5000, 16'd3, 2'b10, 2'b10, 2'b00, 1'b1);
        fire();
        fire();
        fire();

        tag = "R11";
        load_desc(1'b1, 32'h0000_6000, 32'h0000_7000, 16'd0, 2'b10, 2'b10, 2'b10, 1'b0);
        fire();
        fire();

        tag = "R12";
        load_desc(1'b1, 32'hFFFF_FFFE, 32'h0000_0002, 16'd3, 2'b10, 2'b11, 2'b10, 1'b0);
        fire();
        fire();

        // request dropped and descriptor load attempted during a transfer
        tag = "R13";
        load_desc(1'b1, 32'h0000_0040, 32'h0000_0080, 16'd5, 2'b10, 2'b10, 2'b00, 1'b0);
        @(negedge clk); #1;
        flag = 1'b1;
        @(negedge clk); #1;
        flag = 1'b0;
        cfg_load = 1'b1; cfg_enable = 1'b0; cfg_src_addr = 32'hDEAD_0000;
        cfg_count = 16'd1; cfg_src_step = 2'b11; cfg_size = 2'b10; cfg_irq_each = 1'b1;
        @(negedge clk);
        @(negedge clk); #1;
        cfg_load = 1'b0;
        repeat (2) @(negedge clk);
        fire();
        fire();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule